// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a clock buffer may drive its outputs after power comes up. It runs on a free-running timer clock and watches four flags: a supply-good flag, a power-down request, an input-clock-valid flag and a PLL lock flag. When the supply becomes good, it first holds a fixed settling delay. It then waits until an input clock is present, power-down has been released and the PLL reports lock. Only after all of that does it raise the output enable.

The power-down request may arrive asynchronously, so it passes through a synchronizer of configurable depth before the sequencer acts on it. A latched lock status records that lock has been seen, and it clears on power-down or supply loss. A budget watchdog raises a sticky flag if start-up takes too long while an input clock is present.

Top module: `clkseq_top`

## Requirements
- R1: After reset `state_o` reads 0 (power off), and `out_en`, `lock_stat` and `budget_err` are low. State codes on `state_o` are 0 for power off, 1 for startup delay, 2 for waiting, and 3 for running.
- R2: When `supply_ok` is low at a clock edge, `state_o` becomes 0 at that edge, from any state.
- R3: In state 0 a high `supply_ok` moves the sequencer to state 1. It stays in state 1 for exactly `DELAY_CYC` cycles and then enters state 2.
- R4: State 2 moves to state 3 only when, at one edge, `in_clk_ok` is high, `pll_lock` is high and the synchronized power-down request is low. The request is delayed by `SYNC_STAGES` cycles.
- R5: With the supply good and power-down released but `in_clk_ok` low, the sequencer stays in state 2 and `out_en` stays low.
- R6: `out_en` is high exactly when `state_o` is 3.
- R7: A synchronized power-down request in state 3 returns the sequencer to state 2 and clears `out_en`.
- R8: `lock_stat` sets when `pll_lock` is high while the supply is good and the synchronized request is low. It holds after `pll_lock` falls, and it clears when the synchronized request is high or `supply_ok` is low.
- R9: `budget_err` sets once `TIMEOUT_CYC` cycles with `in_clk_ok` high have been spent in states 1 or 2 before state 3 is first reached. It stays set until `supply_ok` goes low.
- R10: Loss of `in_clk_ok` in state 3 returns the sequencer to state 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above its valid threshold |
| pwr_down_req | input | 1 | Power-down request, active high, asynchronous |
| in_clk_ok | input | 1 | Valid input clock detected |
| pll_lock | input | 1 | PLL lock indication |
| out_en | output | 1 | Clock output enable |
| lock_stat | output | 1 | Latched lock status |
| state_o | output | 2 | Current sequencer state code |
| budget_err | output | 1 | Start-up time budget exceeded |

## Verification
A wrong state register shows on `state_o` at the very next edge. Through `out_en`, it shows as an enable that is raised without lock or without an input clock. A delay counter that is off by one moves the state 1 to state 2 transition by one cycle, and the bench catches this by sampling both edges around the boundary. A stale lock latch or a budget counter that is not cleared appears on `lock_stat` or `budget_err` one cycle after a power-down or a supply drop.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_DLY  = 2'd1,
      ST_WAIT = 2'd2,
      ST_RUN  = 2'd3
   } seq_st_e;
endpackage

// File: rtl/clkseq_req_sync.sv
module clkseq_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic req_o
);
   initial begin
      if (STAGES < 0) $error("clkseq_req_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign req_o = req_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= req_i;
            else chain_q <= {chain_q, req_i};
         end
         assign req_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clkseq_delay.sv
module clkseq_delay #(
   parameter int CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic done_o
);
   localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [W-1:0] LOAD_V = W'(CYC - 1);

   initial begin
      if (CYC < 1) $error("clkseq_delay: CYC must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= LOAD_V;
      else if (load_i) cnt_q <= LOAD_V;
      else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/clkseq_budget.sv
module clkseq_budget #(
   parameter int LIMIT = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic cnt_en_i,
   output logic err_o
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

   initial begin
      if (LIMIT < 2) $error("clkseq_budget: LIMIT must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (cnt_en_i && !err_q) begin
         if (cnt_q == LAST_V) err_q <= 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign err_o = err_q;
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top #(
   parameter int DELAY_CYC   = 50000,
   parameter int TIMEOUT_CYC = 200000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       pwr_down_req,
   input  logic       in_clk_ok,
   input  logic       pll_lock,
   output logic       out_en,
   output logic       lock_stat,
   output logic [1:0] state_o,
   output logic       budget_err
);
   import clkseq_pkg::*;

   initial begin
      if (TIMEOUT_CYC <= DELAY_CYC)
         $error("clkseq_top: TIMEOUT_CYC must exceed DELAY_CYC");
   end

   seq_st_e st_q, st_d;
   logic    pd_s;
   logic    dly_done;
   logic    reached_q;
   logic    lock_q;

   clkseq_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .req_i(pwr_down_req), .req_o(pd_s)
   );

   clkseq_delay #(.CYC(DELAY_CYC)) i_delay (
      .clk(clk), .rst_n(rst_n),
      .load_i(st_q == ST_OFF), .run_i(st_q == ST_DLY), .done_o(dly_done)
   );

   clkseq_budget #(.LIMIT(TIMEOUT_CYC)) i_budget (
      .clk(clk), .rst_n(rst_n),
      .clr_i(!supply_ok || st_q == ST_OFF),
      .cnt_en_i((st_q == ST_DLY || st_q == ST_WAIT) && in_clk_ok && !reached_q),
      .err_o(budget_err)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_OFF:  if (supply_ok) st_d = ST_DLY;
         ST_DLY:  if (dly_done) st_d = ST_WAIT;
         ST_WAIT: if (in_clk_ok && !pd_s && pll_lock) st_d = ST_RUN;
         ST_RUN:  if (pd_s || !in_clk_ok) st_d = ST_WAIT;
         default: st_d = ST_OFF;
      endcase
      if (!supply_ok) st_d = ST_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_OFF;
         reached_q <= 1'b0;
         lock_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         if (!supply_ok) reached_q <= 1'b0;
         else if (st_q == ST_RUN) reached_q <= 1'b1;
         if (!supply_ok || pd_s) lock_q <= 1'b0;
         else if (pll_lock) lock_q <= 1'b1;
      end
   end

   assign out_en    = (st_q == ST_RUN);
   assign lock_stat = lock_q;
   assign state_o   = st_q;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       in_clk_ok,
   input logic       pll_lock,
   input logic       out_en,
   input logic       lock_stat,
   input logic [1:0] state_o,
   input logic       budget_err
);
   p_off_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> state_o == 2'd0);

   p_off_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd0 |=> (state_o == 2'd0 || state_o == 2'd1));

   p_en_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> ($past(state_o) == 2'd2 && $past(pll_lock) && $past(in_clk_ok)));

   p_no_clk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && !in_clk_ok) |=> !out_en);

   p_en_is_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_en == (state_o == 2'd3));

   p_lock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !lock_stat);

   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !budget_err);

   p_run_clk_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && !in_clk_ok && supply_ok) |=> state_o == 2'd2);
endmodule

bind clkseq_top clkseq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .in_clk_ok(in_clk_ok),
   .pll_lock(pll_lock), .out_en(out_en), .lock_stat(lock_stat),
   .state_o(state_o), .budget_err(budget_err)
);

// File: tb/test_clkseq_top.sv
module test_clkseq_top;
   localparam int DLY = 8;
   localparam int TMO = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       pwr_down_req = 1'b0;
   logic       in_clk_ok = 1'b0;
   logic       pll_lock = 1'b0;
   logic       out_en, lock_stat, budget_err;
   logic [1:0] state_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   clkseq_top #(.DELAY_CYC(DLY), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) i_clkseq_top (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_down_req(pwr_down_req),
      .in_clk_ok(in_clk_ok), .pll_lock(pll_lock), .out_en(out_en),
      .lock_stat(lock_stat), .state_o(state_o), .budget_err(budget_err)
   );

   // [15] supply [14] pd [13] clk ok [12] lock [11:8] hold [7:6] state [5] en [4] lock_stat
   localparam logic [15:0] VEC [9] = '{
      16'h3400, 16'hEC80, 16'h9490, 16'hA490, 16'hB4F0,
      16'hF480, 16'hB4F0, 16'h9290, 16'h3100
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      chk("R1 state", state_o, 0);
      chk("R1 out_en", out_en, 0);
      chk("R1 lock_stat", lock_stat, 0);
      chk("R1 budget_err", budget_err, 0);
      rst_n = 1'b1;
      step(2);

      for (int i = 0; i < 9; i++) begin
         supply_ok    = VEC[i][15];
         pwr_down_req = VEC[i][14];
         in_clk_ok    = VEC[i][13];
         pll_lock     = VEC[i][12];
         step(int'(VEC[i][11:8]));
         // R2 R4 R5 R6 R7 R8 R10 via table rows
         chk($sformatf("R4/R5/R7/R10/R2 state row %0d", i), state_o, int'(VEC[i][7:6]));
         chk($sformatf("R6 out_en row %0d", i), out_en, int'(VEC[i][5]));
         chk($sformatf("R8 lock_stat row %0d", i), lock_stat, int'(VEC[i][4]));
         chk($sformatf("R9 no err row %0d", i), budget_err, 0);
      end

      // R3 exact delay length
      supply_ok = 1'b0; pwr_down_req = 1'b0; in_clk_ok = 1'b1; pll_lock = 1'b1;
      step(3);
      supply_ok = 1'b1;
      step(1);
      chk("R3 enter delay", state_o, 1);
      step(DLY - 1);
      chk("R3 still delay", state_o, 1);
      step(1);
      chk("R3 leave delay", state_o, 2);
      step(1);
      chk("R4 run", state_o, 3);
      chk("R6 en in run", out_en, 1);

      // R8 lock held after pll_lock drops
      pll_lock = 1'b0;
      step(3);
      chk("R8 lock latched", lock_stat, 1);
      chk("R8 still run", state_o, 3);

      // R9 budget
      supply_ok = 1'b0;
      step(2);
      supply_ok = 1'b1; pwr_down_req = 1'b1; in_clk_ok = 1'b1;
      step(30);
      chk("R9 below budget", budget_err, 0);
      step(20);
      chk("R9 budget exceeded", budget_err, 1);
      chk("R9 stuck wait", state_o, 2);
      supply_ok = 1'b0;
      step(1);
      chk("R9 cleared by supply loss", budget_err, 0);
      chk("R2 off", state_o, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule